// File: doc/BRIEF.md
# Watchdog Control Register Guard

This block is the register front end of a watchdog. It holds the main control word (reload value, user password, end-of-init level and a hardware lock bit), a secondary control register carrying a disable request and a rate request, and a read-only status word assembled from the watchdog core's live state. Software changes the main control word only through a two-write protocol. The first write is a password attempt, and its value must be rebuilt from the live register contents. The second write is a modify attempt, and it must carry fixed guard bits.

The block drives three one-cycle strobes to the watchdog core. One marks a successful unlock, which starts time-out mode. One marks a modify that sets end-of-init, which ends time-out mode and reloads the counter. One marks an access error. The end-of-init level decides whether the secondary register can be written. Settings written there reach the core only when a later modify sets end-of-init. Because the user password can be rotated on every service, the password check also catches a service that is skipped or repeated.

The bus is a single-cycle write/read port with word offsets 0x0 (main control), 0x4 (secondary control) and 0x8 (status). Reads are combinational. Writes take effect at the clock edge. Strobes are registered and appear in the cycle after the write.

Top module: `wdt_guard_regs`

## Requirements
- R1: After reset the main control word reads 0xFFFC0002, the secondary register reads 0, and the end-of-init, disable and rate outputs are 0.
- R2: While locked, a write at offset 0x0 succeeds as a password when all of the following hold: bits [31:16] equal the stored reload value, bits [15:8] equal the stored password, bits [7:4] are 1111, bit 3 equals the disable request, bit 2 equals the rate request, bit 1 equals the inverted lock bit, and bit 0 equals end-of-init. A success clears the lock bit and pulses unlock_o.
- R3: A locked write that differs from the password in any single bit pulses acc_err_o, leaves the word locked and changes no field.
- R4: While unlocked, a write with bit 1 = 1, bits [7:4] = 1111 and bits [3:2] = 00 loads the reload value, password and end-of-init from the write and relocks. endinit_set_o pulses when the written bit 0 is 1.
- R5: An unlocked write with any guard bit wrong (bit 1, or any of bits [7:2]) pulses acc_err_o, changes no field and relocks.
- R6: Reads of offset 0x0 return 0 in bits [7:2] and the hardware lock state in bit 1. The value written to bit 1 is never stored.
- R7: The secondary register keeps bit 3 (disable request) and bit 2 (rate request) and reads 0 elsewhere. It accepts writes only while end-of-init is 0.
- R8: disable_o and rate_sel_o copy the requests only at a successful modify that writes end-of-init = 1. Until then they keep their previous values.
- R9: Offset 0x8 reads {counter[15:0], 10'b0, prewarn, timeout, disable, rate, overflow error, access error flag}. Writes to it change nothing and raise no strobe.
- R10: After a modify changes the password, a password attempt that carries the old password fails with an access error.
- R11: Each strobe lasts one cycle, and at most one strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| addr_i | input | 4 | Byte offset of the word accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| cnt_i | input | 16 | Current watchdog counter value |
| prewarn_i | input | 1 | Core pre-warning flag |
| timeout_i | input | 1 | Core time-out flag |
| ovf_err_i | input | 1 | Core overflow error flag |
| acc_flag_i | input | 1 | Core access error flag |
| unlock_o | output | 1 | Pulse: password accepted, enter time-out mode |
| endinit_set_o | output | 1 | Pulse: modify set end-of-init |
| acc_err_o | output | 1 | Pulse: access error |
| reload_o | output | 16 | Stored reload value |
| endinit_o | output | 1 | End-of-init level |
| disable_o | output | 1 | Applied watchdog disable |
| rate_sel_o | output | 1 | Applied rate select |

## Verification
The hardest state to reach is a correct password after the end-of-init level and the secondary requests have been changed. The key depends on those bits, so the bench keeps a model of every field and rebuilds the key from that model before each attempt. Every one of the 32 password bits is corrupted in turn. Each guard bit of a modify is corrupted in turn, with a fresh unlock before each one. The bench then drops end-of-init, changes the requests, and shows that the applied outputs hold their old values until a modify sets end-of-init again.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned REL_W  = 16;
  localparam int unsigned PW_W   = 8;

  typedef struct packed {
    logic [REL_W-1:0] reload;
    logic [PW_W-1:0]  pw;
    logic [3:0]       guard_hi;
    logic [1:0]       guard_lo;
    logic             lock;
    logic             endinit;
  } ctrl_word_t;

  typedef enum logic [1:0] {SEL_CTRL, SEL_CFG, SEL_STAT, SEL_NONE} reg_sel_e;
endpackage

// File: rtl/wdt_key_check.sv
module wdt_key_check
  import wdt_guard_pkg::*;
(
  input  ctrl_word_t       wr_word_i,
  input  logic [REL_W-1:0] reload_i,
  input  logic [PW_W-1:0]  pw_i,
  input  logic             endinit_i,
  input  logic             lock_i,
  input  logic             dis_req_i,
  input  logic             rate_req_i,
  output logic             key_ok_o,
  output logic             mod_ok_o
);
  logic hi_ok;
  assign hi_ok = &wr_word_i.guard_hi;

  // password: live contents, lock inverted, guard_lo mirrors secondary requests
  assign key_ok_o = hi_ok
                 && (wr_word_i.reload   == reload_i)
                 && (wr_word_i.pw       == pw_i)
                 && (wr_word_i.guard_lo == {dis_req_i, rate_req_i})
                 && (wr_word_i.lock     == ~lock_i)
                 && (wr_word_i.endinit  == endinit_i);

  assign mod_ok_o = hi_ok && (wr_word_i.guard_lo == 2'b00) && wr_word_i.lock;
endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic dis_d_i,
  input  logic rate_d_i,
  input  logic endinit_i,
  input  logic apply_i,
  output logic dis_req_o,
  output logic rate_req_o,
  output logic dis_o,
  output logic rate_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_req_o  <= 1'b0;
      rate_req_o <= 1'b0;
    end else if (wr_i && !endinit_i) begin
      dis_req_o  <= dis_d_i;
      rate_req_o <= rate_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_o  <= 1'b0;
      rate_o <= 1'b0;
    end else if (apply_i) begin
      dis_o  <= dis_req_o;
      rate_o <= rate_req_o;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({dis_req_o, rate_req_o}) |-> !$past(endinit_i)) else $error("cfg written while end-of-init set"); // R7
  AST_APPLY_ONLY_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({dis_o, rate_o}) |-> $past(apply_i)) else $error("applied settings changed without end-of-init set"); // R8
endmodule

// File: rtl/wdt_guard_regs.sv
module wdt_guard_regs
  import wdt_guard_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 4'h0,
  parameter logic [ADDR_W-1:0] CFG_OFS  = 4'h4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 4'h8,
  parameter logic [15:0]     RST_RELOAD = 16'hFFFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [15:0]       cnt_i,
  input  logic              prewarn_i,
  input  logic              timeout_i,
  input  logic              ovf_err_i,
  input  logic              acc_flag_i,
  output logic              unlock_o,
  output logic              endinit_set_o,
  output logic              acc_err_o,
  output logic [15:0]       reload_o,
  output logic              endinit_o,
  output logic              disable_o,
  output logic              rate_sel_o
);
  localparam int unsigned PAD_W = WORD_W - REL_W - 6;

  reg_sel_e         sel;
  ctrl_word_t       wr_word;
  logic [REL_W-1:0] reload_q;
  logic [PW_W-1:0]  pw_q;
  logic             ei_q, lock_q;
  logic             unlock_q, eiset_q, err_q;
  logic             dis_req, rate_req, dis_app, rate_app;
  logic             key_ok, mod_ok, pw_try, mod_try, apply;

  always_comb begin
    if      (addr_i == CTRL_OFS) sel = SEL_CTRL;
    else if (addr_i == CFG_OFS)  sel = SEL_CFG;
    else if (addr_i == STAT_OFS) sel = SEL_STAT;
    else                         sel = SEL_NONE;
  end

  assign wr_word = ctrl_word_t'(wdata_i);
  assign pw_try  = wr_en_i && (sel == SEL_CTRL) && lock_q;
  assign mod_try = wr_en_i && (sel == SEL_CTRL) && !lock_q;
  assign apply   = mod_try && mod_ok && wr_word.endinit;

  wdt_key_check i_key (
    .wr_word_i  (wr_word),
    .reload_i   (reload_q),
    .pw_i       (pw_q),
    .endinit_i  (ei_q),
    .lock_i     (lock_q),
    .dis_req_i  (dis_req),
    .rate_req_i (rate_req),
    .key_ok_o   (key_ok),
    .mod_ok_o   (mod_ok)
  );

  wdt_cfg_reg i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i && (sel == SEL_CFG)),
    .dis_d_i    (wdata_i[3]),
    .rate_d_i   (wdata_i[2]),
    .endinit_i  (ei_q),
    .apply_i    (apply),
    .dis_req_o  (dis_req),
    .rate_req_o (rate_req),
    .dis_o      (dis_app),
    .rate_o     (rate_app)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RST_RELOAD;
      pw_q     <= '0;
      ei_q     <= 1'b0;
      lock_q   <= 1'b1;
      unlock_q <= 1'b0;
      eiset_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unlock_q <= 1'b0;
      eiset_q  <= 1'b0;
      err_q    <= 1'b0;
      if (pw_try) begin
        if (key_ok) begin
          lock_q   <= 1'b0;
          unlock_q <= 1'b1;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (mod_try) begin
        lock_q <= 1'b1;
        if (mod_ok) begin
          reload_q <= wr_word.reload;
          pw_q     <= wr_word.pw;
          ei_q     <= wr_word.endinit;
          eiset_q  <= wr_word.endinit;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata_o = {reload_q, pw_q, 6'b0, lock_q, ei_q};
      SEL_CFG:  rdata_o = {28'b0, dis_req, rate_req, 2'b0};
      SEL_STAT: rdata_o = {cnt_i, {PAD_W{1'b0}}, prewarn_i, timeout_i,
                           dis_app, rate_app, ovf_err_i, acc_flag_i};
      default:  rdata_o = '0;
    endcase
  end

  assign unlock_o      = unlock_q;
  assign endinit_set_o = eiset_q;
  assign acc_err_o     = err_q;
  assign reload_o      = reload_q;
  assign endinit_o     = ei_q;
  assign disable_o     = dis_app;
  assign rate_sel_o    = rate_app;

  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({unlock_o, endinit_set_o, acc_err_o})) else $error("strobes overlap"); // R11
  AST_UNLOCK_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |-> !lock_q) else $error("unlock without clearing lock"); // R2
  AST_ERR_KEEPS_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> ($stable({reload_q, pw_q, ei_q}) && lock_q)) else $error("error changed fields"); // R3
  AST_EISET_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    endinit_set_o |-> (endinit_o && lock_q)) else $error("end-of-init strobe inconsistent"); // R4
  AST_UNLOCK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |=> !unlock_o) else $error("unlock strobe stretched"); // R11
endmodule

// File: tb/test_wdt_guard_regs.sv
`timescale 1ns/1ps
module test_wdt_guard_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] cnt = 16'h1234;
  logic        prewarn = 1'b1, timeout = 1'b0, ovf = 1'b1, accf = 1'b0;
  logic        unlock, eiset, err, ei, dis, rate;
  logic [15:0] reload;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_rel = 16'hFFFC;
  logic [7:0]  m_pw = 8'h00;
  logic        m_ei = 1'b0, m_dreq = 1'b0, m_rreq = 1'b0, m_dis = 1'b0, m_rate = 1'b0;

  always #2.5 clk = ~clk;

  wdt_guard_regs i_wdt_guard_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cnt_i(cnt), .prewarn_i(prewarn), .timeout_i(timeout),
    .ovf_err_i(ovf), .acc_flag_i(accf), .unlock_o(unlock), .endinit_set_o(eiset),
    .acc_err_o(err), .reload_o(reload), .endinit_o(ei), .disable_o(dis), .rate_sel_o(rate)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] key_w(input logic [7:0] pw);
    return {m_rel, pw, 4'hF, m_dreq, m_rreq, 1'b0, m_ei};
  endfunction

  function automatic logic [31:0] mod_w(input logic [15:0] rel, input logic [7:0] pw, input logic e);
    return {rel, pw, 4'hF, 2'b00, 1'b1, e};
  endfunction

  function automatic logic [31:0] ctrl_exp(input logic lk);
    return {m_rel, m_pw, 6'b0, lk, m_ei};
  endfunction

  // exp_s = {unlock, endinit_set, acc_err}
  task automatic do_wr(input logic [3:0] a, input logic [31:0] d, input logic [2:0] exp_s, input string tag);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk(tag, {29'b0, unlock, eiset, err}, {29'b0, exp_s});
    @(negedge clk);
    chk("R11", {29'b0, unlock, eiset, err}, 32'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_unlock();
    do_wr(4'h0, key_w(m_pw), 3'b100, "R2");
  endtask

  task automatic do_mod(input logic [15:0] rel, input logic [7:0] pw, input logic e);
    do_wr(4'h0, mod_w(rel, pw, e), {1'b0, e, 1'b0}, "R4");
    m_rel = rel; m_pw = pw; m_ei = e;
    if (e) begin m_dis = m_dreq; m_rate = m_rreq; end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, v); chk("R1", v, 32'hFFFC0002);
    rd(4'h4, v); chk("R1", v, 32'h0);
    chk("R1", {29'b0, ei, dis, rate}, 32'h0);
    chk("R1", {16'b0, reload}, 32'h0000FFFC);

    // R9 status layout and ignored writes
    rd(4'h8, v); chk("R9", v, {16'h1234, 10'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
    do_wr(4'h8, 32'hFFFFFFFF, 3'b000, "R9");
    rd(4'h8, v); chk("R9", v, {16'h1234, 10'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});

    // R7 secondary write while end-of-init is 0
    do_wr(4'h4, 32'hFFFFFFFF, 3'b000, "R7");
    m_dreq = 1'b1; m_rreq = 1'b1;
    rd(4'h4, v); chk("R7", v, 32'h0000000C);
    chk("R8", {30'b0, dis, rate}, 32'h0);

    // R3 single-bit corruptions of the password
    for (int i = 0; i < 32; i++) begin
      do_wr(4'h0, key_w(m_pw) ^ (32'h1 << i), 3'b001, "R3");
      rd(4'h0, v); chk("R3", v, ctrl_exp(1'b1));
    end

    // R2 / R6 correct password, lock reads 0
    do_unlock();
    rd(4'h0, v); chk("R6", v, ctrl_exp(1'b0));

    // R5 each guard bit wrong during modify
    for (int i = 1; i < 8; i++) begin
      if (i > 1) do_unlock();
      do_wr(4'h0, mod_w(16'h1111, 8'h22, 1'b1) ^ (32'h1 << i), 3'b001, "R5");
      rd(4'h0, v); chk("R5", v, ctrl_exp(1'b1));
    end

    // R4 / R8 valid modify setting end-of-init
    do_unlock();
    do_mod(16'hABCD, 8'h5A, 1'b1);
    chk("R4", {15'b0, ei, reload}, {15'b0, 1'b1, 16'hABCD});
    rd(4'h0, v); chk("R6", v, 32'hABCD5A03);
    chk("R8", {30'b0, dis, rate}, {30'b0, m_dis, m_rate});

    // R7 secondary frozen while end-of-init is 1
    do_wr(4'h4, 32'h0, 3'b000, "R7");
    rd(4'h4, v); chk("R7", v, 32'h0000000C);

    // R10 old and rotated passwords
    do_wr(4'h0, key_w(8'h00), 3'b001, "R10");
    do_unlock();
    do_mod(16'hABCD, 8'h77, 1'b1);
    do_wr(4'h0, key_w(8'h5A), 3'b001, "R10");
    rd(4'h0, v); chk("R10", v, ctrl_exp(1'b1));

    // R8 settings delayed until end-of-init set
    do_unlock();
    do_mod(16'h0100, 8'h77, 1'b0);
    chk("R4", {31'b0, ei}, 32'h0);
    do_wr(4'h4, 32'h0, 3'b000, "R7");
    m_dreq = 1'b0; m_rreq = 1'b0;
    chk("R8", {30'b0, dis, rate}, 32'h3);
    do_unlock();
    do_mod(16'h0100, 8'h77, 1'b1);
    chk("R8", {30'b0, dis, rate}, 32'h0);
    rd(4'h8, v); chk("R9", v, {16'h1234, 10'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule